// File: doc/BRIEF.md
# Serial Audio Link Reset and Wake Sequencer

This block sits on the controller side of a serial audio codec link. It brings the link up from power-on or from a low-power halted state. It drives the codec's active-low reset line and the wake level on the frame sync line, and it watches whether the codec's bit clock is toggling. It declares the link up once the codec-ready flag arrives in the incoming tag slot. Software-facing logic issues one-cycle command pulses for a cold reset, a warm reset and a power-down notice, and reads back a state code, a link-up flag and a sticky error flag.

A cold reset holds the codec reset line low for a fixed time measured on the local clock. The codec registers then return to their defaults. A warm reset leaves those registers alone. It is only legal while the bit clock is stopped, so its sync pulse is timed in microseconds on the free-running local clock. After a power-down notice, the sequencer keeps sync low for a parameterised number of frame times. A frame is counted as 256 bit-clock rises while the codec clock runs. When the clock has stopped, the same frame time is counted in local cycles instead.

Top module: `aclink_wake_seq`

## Requirements
- R1: After reset, `link_state` is 0 (idle), `codec_rst_n` is 1, and `sync_wake`, `link_up`, `link_err` and `bclk_alive` are 0.
- R2: `cmd_cold` is accepted in every state. On the next cycle `link_state` is 1 and `codec_rst_n` is 0. `codec_rst_n` stays low for exactly RST_US microseconds of local cycles (50 by default), and then `link_state` becomes 3 (waiting for bit clock).
- R3: `cmd_warm`, given in idle while the bit clock is stopped, moves `link_state` to 2. `sync_wake` is then high for exactly WARM_US microseconds of local cycles (50 by default) and returns low as `link_state` becomes 3.
- R4: `cmd_warm` has no effect while the bit clock is toggling, and has no effect in any state other than idle.
- R5: `bclk_alive` rises a few cycles after bit-clock edges appear. It falls once no edge has been seen for BCLK_TIMEOUT local cycles (16 by default).
- R6: State 3 moves to 4 (waiting for ready) once `bclk_alive` is 1. State 4 moves to 5 (link up, with `link_up` = 1) on a `tag_strobe` with `tag_ready` set. A strobe with `tag_ready` clear is ignored.
- R7: `cmd_pd` in state 5 moves to state 6 (hold-off). In state 6 `sync_wake` stays low and `cmd_warm` is ignored. The sequencer returns to idle after HOLDOFF_FRAMES frames (4 by default), each of 256 bit-clock rises while the clock runs.
- R8: If ready is not seen within READY_FRAMES frames (8 by default) of accepting a cold or warm command, `link_state` shows 7 for one cycle and then 0, and `link_err` is set. `link_err` stays set until the next accepted cold or warm command.
- R9: While the bit clock is stopped, a frame lasts CLK_HZ/1000·256/12288 local cycles (1041 by default), so the hold-off still ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk | input | 1 | Codec bit clock, asynchronous |
| cmd_cold | input | 1 | Cold reset command pulse |
| cmd_warm | input | 1 | Warm reset command pulse |
| cmd_pd | input | 1 | Power-down notice pulse |
| tag_strobe | input | 1 | One-cycle pulse: a slot-0 tag has been received |
| tag_ready | input | 1 | Codec-ready bit of that tag (bit 15) |
| codec_rst_n | output | 1 | Active-low codec reset |
| sync_wake | output | 1 | Wake level for the sync line |
| bclk_alive | output | 1 | Bit clock detected as toggling |
| link_up | output | 1 | Link ready |
| link_err | output | 1 | Sticky ready-timeout flag |
| link_state | output | 3 | State code 0..7 |

## Verification
State and the reset and sync outputs are decoded from the state register. They change one cycle after the accepting clock edge, so the bench drives commands on the falling edge and reads results on the next falling edge. Pulse widths are counted in falling-edge samples and must equal the parameterised cycle counts exactly. Hold-off and timeout durations depend on the bit-clock phase through the two-flop synchronizer. These are checked within a window of a few cycles around 1024 local cycles per running frame, or 1041 per stopped frame. The clock-stopped flag is checked against the timeout plus the synchronizer delay.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_COLD_RST   = 3'd1,
    ST_WARM_PULSE = 3'd2,
    ST_WAIT_CLK   = 3'd3,
    ST_WAIT_READY = 3'd4,
    ST_LINK_UP    = 3'd5,
    ST_PD_HOLDOFF = 3'd6,
    ST_ERROR      = 3'd7
  } link_st_t;
endpackage

// File: rtl/aclink_bclk_mon.sv
module aclink_bclk_mon #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_clk,
  output logic bclk_rise,
  output logic bclk_alive
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic [2:0]    sh_q;
  logic [CW-1:0] idle_q, idle_d;
  logic          edge_seen;

  assign edge_seen = sh_q[2] ^ sh_q[1];
  assign bclk_rise = sh_q[1] & ~sh_q[2];

  always_comb begin
    idle_d = idle_q;
    if (edge_seen)                   idle_d = '0;
    else if (idle_q != CW'(TIMEOUT)) idle_d = idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idle_q <= CW'(TIMEOUT);
    end else begin
      sh_q   <= {sh_q[1:0], bit_clk};
      idle_q <= idle_d;
    end
  end

  assign bclk_alive = (idle_q != CW'(TIMEOUT));

  assert_alive_needs_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk_alive) |-> $past(edge_seen));
endmodule

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer #(
  parameter int FRAME_BITS  = 256,
  parameter int FRAME_LOCAL = 1041
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bclk_alive,
  input  logic bclk_rise,
  output logic frame_tick
);
  localparam int FMAX = (FRAME_LOCAL > FRAME_BITS) ? FRAME_LOCAL : FRAME_BITS;
  localparam int FW   = $clog2(FMAX + 1);

  logic [FW-1:0] cnt_q, cnt_d, limit;
  logic          step;

  assign step       = bclk_alive ? bclk_rise : 1'b1;
  assign limit      = bclk_alive ? FW'(FRAME_BITS - 1) : FW'(FRAME_LOCAL - 1);
  assign frame_tick = !clr && step && (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)             cnt_d = '0;
    else if (frame_tick) cnt_d = '0;
    else if (step)       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_frame_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (cnt_q == '0));
endmodule

// File: rtl/aclink_span_timer.sv
module aclink_span_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  assert_timer_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == '0 && !$past(load)) |-> (cnt_q == '0));
endmodule

// File: rtl/aclink_wake_seq.sv
module aclink_wake_seq
  import aclink_pkg::*;
#(
  parameter int CLK_HZ         = 50_000_000,
  parameter int BCLK_HZ        = 12_288_000,
  parameter int RST_US         = 1,
  parameter int WARM_US        = 1,
  parameter int BCLK_TIMEOUT   = 16,
  parameter int FRAME_BITS     = 256,
  parameter int HOLDOFF_FRAMES = 4,
  parameter int READY_FRAMES   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_clk,
  input  logic       cmd_cold,
  input  logic       cmd_warm,
  input  logic       cmd_pd,
  input  logic       tag_strobe,
  input  logic       tag_ready,
  output logic       codec_rst_n,
  output logic       sync_wake,
  output logic       bclk_alive,
  output logic       link_up,
  output logic       link_err,
  output logic [2:0] link_state
);
  localparam int CYC_PER_US  = CLK_HZ / 1_000_000;
  localparam int RST_CYC     = RST_US * CYC_PER_US;
  localparam int WARM_CYC    = WARM_US * CYC_PER_US;
  localparam int SPAN_MAX    = (RST_CYC > WARM_CYC) ? RST_CYC : WARM_CYC;
  localparam int TW          = $clog2(SPAN_MAX + 1);
  localparam int FRAME_LOCAL = (CLK_HZ / 1000) * FRAME_BITS / (BCLK_HZ / 1000);
  localparam int FR_MAX      = (READY_FRAMES > HOLDOFF_FRAMES) ? READY_FRAMES : HOLDOFF_FRAMES;
  localparam int NW          = $clog2(FR_MAX + 1);

  logic          rs1_q, rs2_q;
  link_st_t      st_q, st_d;
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic          bclk_rise, frame_tick, frm_clr, ready_expired;
  logic [NW-1:0] frm_q, frm_d;
  logic          err_q, err_d;

  // reset: asserted asynchronously, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  aclink_bclk_mon #(.TIMEOUT(BCLK_TIMEOUT)) u_mon (
    .clk(clk), .rst_n(rs2_q), .bit_clk(bit_clk),
    .bclk_rise(bclk_rise), .bclk_alive(bclk_alive));

  aclink_frame_timer #(.FRAME_BITS(FRAME_BITS), .FRAME_LOCAL(FRAME_LOCAL)) u_frm (
    .clk(clk), .rst_n(rs2_q), .clr(frm_clr), .bclk_alive(bclk_alive),
    .bclk_rise(bclk_rise), .frame_tick(frame_tick));

  aclink_span_timer #(.TW(TW)) u_span (
    .clk(clk), .rst_n(rs2_q), .load(tmr_load), .load_val(tmr_val), .done(tmr_done));

  assign ready_expired = frame_tick && (frm_q == NW'(READY_FRAMES - 1));

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_IDLE: if (cmd_warm && !bclk_alive) begin
        st_d     = ST_WARM_PULSE;
        tmr_load = 1'b1;
        tmr_val  = TW'(WARM_CYC - 1);
      end
      ST_COLD_RST:   if (tmr_done) st_d = ST_WAIT_CLK;
      ST_WARM_PULSE: if (tmr_done) st_d = ST_WAIT_CLK;
      ST_WAIT_CLK: begin
        if (ready_expired)   st_d = ST_ERROR;
        else if (bclk_alive) st_d = ST_WAIT_READY;
      end
      ST_WAIT_READY: begin
        if (ready_expired)                  st_d = ST_ERROR;
        else if (tag_strobe && tag_ready)   st_d = ST_LINK_UP;
      end
      ST_LINK_UP: if (cmd_pd) st_d = ST_PD_HOLDOFF;
      ST_PD_HOLDOFF:
        if (frame_tick && frm_q == NW'(HOLDOFF_FRAMES - 1)) st_d = ST_IDLE;
      ST_ERROR: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    if (cmd_cold) begin
      st_d     = ST_COLD_RST;
      tmr_load = 1'b1;
      tmr_val  = TW'(RST_CYC - 1);
    end
  end

  assign frm_clr = tmr_load || (st_q == ST_LINK_UP && st_d == ST_PD_HOLDOFF);

  always_comb begin
    frm_d = frm_q;
    if (frm_clr)                                 frm_d = '0;
    else if (frame_tick && frm_q != NW'(FR_MAX)) frm_d = frm_q + 1'b1;
  end

  always_comb begin
    err_d = err_q;
    if (tmr_load)               err_d = 1'b0;
    else if (st_d == ST_ERROR)  err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rs2_q) begin
    if (!rs2_q) begin
      st_q  <= ST_IDLE;
      frm_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      frm_q <= frm_d;
      err_q <= err_d;
    end
  end

  assign codec_rst_n = (st_q != ST_COLD_RST);
  assign sync_wake   = (st_q == ST_WARM_PULSE);
  assign link_up     = (st_q == ST_LINK_UP);
  assign link_err    = err_q;
  assign link_state  = st_q;

  assert_cold_from_cmd_R2: assert property (@(posedge clk) disable iff (!rs2_q)
    $fell(codec_rst_n) |-> $past(cmd_cold));
  assert_warm_only_stopped_R4: assert property (@(posedge clk) disable iff (!rs2_q)
    $rose(sync_wake) |-> ($past(!bclk_alive) && $past(st_q == ST_IDLE)));
  assert_ready_tag_R6: assert property (@(posedge clk) disable iff (!rs2_q)
    $rose(link_up) |-> $past(tag_strobe && tag_ready));
  assert_holdoff_len_R7: assert property (@(posedge clk) disable iff (!rs2_q)
    ($past(st_q == ST_PD_HOLDOFF) && st_q == ST_IDLE) |->
      ($past(frm_q) == NW'(HOLDOFF_FRAMES - 1) && $past(frame_tick)));
  assert_err_on_frame_R8: assert property (@(posedge clk) disable iff (!rs2_q)
    $rose(link_err) |-> $past(frame_tick));
endmodule

// File: tb/aclink_wake_seq_bench.sv
module aclink_wake_seq_bench;
  localparam int RST_CYC  = 50;
  localparam int WARM_CYC = 50;
  localparam int TMO      = 16;
  localparam int FR_RUN   = 1024;
  localparam int FR_STOP  = 1041;

  logic clk = 1'b0, rst_n = 1'b0, bit_clk = 1'b0, bclk_en = 1'b0;
  logic cmd_cold = 1'b0, cmd_warm = 1'b0, cmd_pd = 1'b0;
  logic tag_strobe = 1'b0, tag_ready = 1'b0;
  logic codec_rst_n, sync_wake, bclk_alive, link_up, link_err;
  logic [2:0] link_state;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  aclink_wake_seq u_aclink_wake_seq (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .cmd_cold(cmd_cold),
    .cmd_warm(cmd_warm), .cmd_pd(cmd_pd), .tag_strobe(tag_strobe),
    .tag_ready(tag_ready), .codec_rst_n(codec_rst_n), .sync_wake(sync_wake),
    .bclk_alive(bclk_alive), .link_up(link_up), .link_err(link_err),
    .link_state(link_state));

  always #10 clk = ~clk;
  always #40 bit_clk = bclk_en ? ~bit_clk : 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  task automatic count_while(input logic [2:0] s, output int n);
    n = 0;
    while (link_state == s && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(4);
    chk(link_state == 3'd0, "R1 state", link_state, 0);
    chk(codec_rst_n && !sync_wake, "R1 rst/sync", {codec_rst_n, sync_wake}, 2);
    chk(!link_up && !link_err && !bclk_alive, "R1 flags", {link_up, link_err, bclk_alive}, 0);
  endtask

  task automatic t_warm_with_clock;
    bclk_en = 1'b1;
    wait_cyc(30);
    chk(bclk_alive, "R5 alive after edges", bclk_alive, 1);
    pulse(cmd_warm);
    chk(link_state == 3'd0 && !sync_wake, "R4 warm ignored while clock runs", link_state, 0);
  endtask

  task automatic t_cold_to_link;
    int n;
    pulse(cmd_cold);
    chk(link_state == 3'd1 && !codec_rst_n, "R2 cold entry", link_state, 1);
    count_while(3'd1, n);
    chk(n == RST_CYC, "R2 reset width", n, RST_CYC);
    chk(codec_rst_n && link_state == 3'd3, "R2 after reset", link_state, 3);
    wait_cyc(2);
    chk(link_state == 3'd4, "R6 clock seen", link_state, 4);
    tag_ready = 1'b0;
    pulse(tag_strobe);
    chk(link_state == 3'd4 && !link_up, "R6 not-ready tag ignored", link_state, 4);
    tag_ready = 1'b1;
    pulse(tag_strobe);
    tag_ready = 1'b0;
    chk(link_state == 3'd5 && link_up, "R6 link up", link_state, 5);
    pulse(cmd_warm);
    chk(link_state == 3'd5 && !sync_wake, "R4 warm ignored in link up", link_state, 5);
  endtask

  task automatic t_holdoff_running;
    int n;
    pulse(cmd_pd);
    chk(link_state == 3'd6, "R7 holdoff entry", link_state, 6);
    pulse(cmd_warm);
    chk(link_state == 3'd6 && !sync_wake, "R7 warm ignored in holdoff", sync_wake, 0);
    count_while(3'd6, n);
    n = n + 2;
    chk(n >= 4*FR_RUN - 8 && n <= 4*FR_RUN + 8, "R7 holdoff length", n, 4*FR_RUN);
    chk(link_state == 3'd0, "R7 back to idle", link_state, 0);
  endtask

  task automatic t_clock_stop;
    int n = 0;
    bclk_en = 1'b0;
    while (bclk_alive && n < 200) begin
      n++;
      @(negedge clk);
    end
    chk(n >= TMO - 2 && n <= TMO + 8, "R5 stop detect delay", n, TMO);
  endtask

  task automatic t_warm_to_link;
    int n;
    pulse(cmd_warm);
    chk(link_state == 3'd2 && sync_wake, "R3 warm entry", link_state, 2);
    count_while(3'd2, n);
    chk(n == WARM_CYC, "R3 sync pulse width", n, WARM_CYC);
    chk(!sync_wake && link_state == 3'd3, "R3 sync low, waiting clock", link_state, 3);
    wait_cyc(10);
    chk(link_state == 3'd3, "R6 holds without clock", link_state, 3);
    bclk_en = 1'b1;
    wait_cyc(12);
    chk(link_state == 3'd4, "R6 clock seen after warm", link_state, 4);
    tag_ready = 1'b1;
    pulse(tag_strobe);
    tag_ready = 1'b0;
    chk(link_up, "R6 link up after warm", link_up, 1);
  endtask

  task automatic t_holdoff_stopped;
    int n;
    pulse(cmd_pd);
    bclk_en = 1'b0;
    count_while(3'd6, n);
    chk(n >= 4*FR_STOP - 20 && n <= 4*FR_STOP + 40, "R9 stopped-clock holdoff", n, 4*FR_STOP);
  endtask

  task automatic t_timeout;
    int n = 0;
    bclk_en = 1'b1;
    wait_cyc(30);
    pulse(cmd_cold);
    n = 1;
    while (!link_err && n < 20000) begin
      n++;
      @(negedge clk);
    end
    chk(n >= 8*FR_RUN - 10 && n <= 8*FR_RUN + 10, "R8 timeout delay", n, 8*FR_RUN);
    chk(link_state == 3'd7, "R8 error state", link_state, 7);
    wait_cyc(1);
    chk(link_state == 3'd0 && link_err, "R8 idle, flag held", {link_state, link_err}, 1);
    wait_cyc(20);
    chk(link_err, "R8 flag sticky", link_err, 1);
    pulse(cmd_cold);
    chk(!link_err && link_state == 3'd1, "R8 flag cleared by cold", link_err, 0);
    wait_cyc(60);
    pulse(cmd_cold);
    chk(link_state == 3'd1, "R2 cold from waiting state", link_state, 1);
  endtask

  initial begin
    t_reset();
    t_warm_with_clock();
    t_cold_to_link();
    t_holdoff_running();
    t_clock_stop();
    t_warm_to_link();
    t_holdoff_stopped();
    t_timeout();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule